// File: doc/BRIEF.md
# Transition-Coded Line Transmitter with Refresh

This block drives the transmit half of a set of isolated logic lines. Each line is either a transmitter or a receiver. For every transmitting line it follows a synchronous digital input and, whenever the input level changes, sends one single-cycle command toward the barrier link. A set-high command means the line rose and a set-low command means it fell. Levels are never streamed. Only changes, plus a slow periodic restatement, cross the link.

A background scheduler restates the level of every transmitting line once per scan period, given in clock cycles. A line that already sent an edge command during the previous period is left out of the next scan. This lets a far side that lost an edge recover without sending redundant traffic. A side enable freezes the captured input levels. When the enable returns, every transmitting line is restated at once. After reset the block fills its synchronizer silently, then opens with a full restatement.

Top module: `edge_cmd_tx`

## Requirements
- R1: A rising level on a transmitting input, sampled at clock edge k, gives `cmd_hi` high for that line for exactly one cycle after edge k+2.
- R2: A falling level on a transmitting input, sampled at edge k, gives `cmd_lo` high for that line for exactly one cycle after edge k+2.
- R3: A line whose `dir_cfg` bit is 0 is a receiver and never raises `cmd_hi` or `cmd_lo`. A bit value of 1 marks a transmitter.
- R4: `cmd_hi` and `cmd_lo` are never both high on the same line. If an edge and a scheduled restatement fall on the same line in the same cycle, exactly one command is sent, carrying the new level. The line then counts as active for the period just starting.
- R5: Scan instants occur every REFRESH_CYC cycles, starting at the first post-reset command cycle. At each scan instant, every transmitting line that sent no edge command since the previous scan instant gets a command matching its present level.
- R6: Every transmitting line gets some command at least once in any window of 2*REFRESH_CYC cycles.
- R7: While `en_side` is 0, the captured levels hold and input changes produce no edge commands.
- R8: On the cycle after `en_side` is sampled 1 following a sampled 0, every transmitting line gets a command with its current synchronized level.
- R9: During reset both command outputs are 0. After release, the first SYNC_STAGES+1 edges emit nothing, including for inputs that differ from the reset level. The next edge restates every transmitting line.
- R10: A transmitting input pulse held for MIN pulse width (5 cycles at a 200 MHz clock) while enabled produces both of its edge commands, 5 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_side | input | 1 | Side enable; 0 freezes the captured input levels |
| dir_cfg | input | NUM_LINES | Per-line direction, 1 = transmitter, 0 = receiver |
| din | input | NUM_LINES | Asynchronous line inputs |
| cmd_hi | output | NUM_LINES | One-cycle set-high commands |
| cmd_lo | output | NUM_LINES | One-cycle set-low commands |

## Verification
The checker watches four things on every cycle:
- the two command polarities stay mutually exclusive;
- receivers stay silent;
- the outputs are quiet on the first cycle after reset;
- the enable-return restatement covers exactly the transmitting lines.

A per-line counter also bounds the gap between commands to two scan periods. The following can only be shown by the bench's scenarios, because they depend on timed input stories rather than on a single-cycle relation:
- the exact three-edge latency from input to command;
- the freeze while disabled;
- skipping lines that were active in the previous period;
- the merge of a coincident edge and restatement;
- the silent synchronizer fill after reset.

// File: rtl/edge_cmd_tx_pkg.sv
// Shared types and constants for the transition-coded line transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package edge_cmd_tx_pkg;

    // Scheduler phase: filling the synchronizer, then running scans.
    typedef enum logic {
        SCH_FILL = 1'b0,
        SCH_RUN  = 1'b1
    } sched_phase_e;

    // Default number of lines handled by one block.
    localparam int unsigned DEF_LINES = 5;

endpackage

// File: rtl/edge_cmd_tx_sync.sv
// Multi-stage synchronizer for the asynchronous line inputs.
// Assumes: STAGES >= 2; each bit is an independent level signal.
module edge_cmd_tx_sync #(
    parameter int unsigned NL     = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] d_async,
    output logic [NL-1:0] d_sync
);
    logic [STAGES-1:0][NL-1:0] chain;

    // Shift the inputs through the flop chain; stage 0 samples the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d_async;
            for (int s = 1; s < int'(STAGES); s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/edge_cmd_tx_capture.sv
// Enable-controlled input latch and edge finder.
// The latch follows the synchronized level while the side is enabled,
// and also while the scheduler is still filling.
// It holds its value while the side is disabled.
// Assumes: live goes high only after the synchronizer holds valid data.
module edge_cmd_tx_capture #(
    parameter int unsigned NL = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          live,
    input  logic          en_side,
    input  logic [NL-1:0] d_sync,
    output logic [NL-1:0] lvl_next,
    output logic [NL-1:0] edge_v
);
    logic [NL-1:0] held;
    logic          open_w;

    // Latch is transparent when enabled or while filling after reset.
    assign open_w   = en_side || !live;
    assign lvl_next = open_w ? d_sync : held;

    // An edge is a change of the captured level once the block is live.
    assign edge_v   = live ? (lvl_next ^ held) : '0;

    // Hold register for the captured line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else begin
            held <= lvl_next;
        end
    end
endmodule

// File: rtl/edge_cmd_tx_sched.sv
// Refresh scheduler.
// It waits WARM cycles after reset so the synchronizer and latch fill.
// It then issues a scan tick on the first running cycle and every
// PERIOD cycles after that.
// Assumes: PERIOD >= 2, WARM >= 1.
module edge_cmd_tx_sched
    import edge_cmd_tx_pkg::*;
#(
    parameter int unsigned PERIOD = 1000,
    parameter int unsigned WARM   = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic live,
    output logic tick
);
    localparam int unsigned PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam int unsigned WW = $clog2(WARM + 1);

    sched_phase_e   phase;
    logic [WW-1:0]  warm_cnt;
    logic [PW-1:0]  per_cnt;

    assign live = (phase == SCH_RUN);
    assign tick = live && (per_cnt == '0);

    // Fill phase: count the warm-up cycles, then switch to running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= SCH_FILL;
            warm_cnt <= '0;
        end else if (phase == SCH_FILL) begin
            if (warm_cnt == WW'(WARM - 1)) begin
                phase <= SCH_RUN;
            end else begin
                warm_cnt <= warm_cnt + 1'b1;
            end
        end
    end

    // Period counter: wraps every PERIOD running cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_cnt <= '0;
        end else if (live) begin
            if (per_cnt == PW'(PERIOD - 1)) begin
                per_cnt <= '0;
            end else begin
                per_cnt <= per_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/edge_cmd_tx_arb.sv
// Command arbiter.
// It merges edge requests, scan restatements of quiet lines and the
// forced restatement on enable return into one registered command per
// line. The command always carries the line's new level, so an edge
// wins over a restatement in the same cycle.
// Assumes: dir_cfg is static during operation.
module edge_cmd_tx_arb #(
    parameter int unsigned NL = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          live,
    input  logic          tick,
    input  logic          en_side,
    input  logic [NL-1:0] dir_cfg,
    input  logic [NL-1:0] lvl_next,
    input  logic [NL-1:0] edge_v,
    output logic [NL-1:0] cmd_hi,
    output logic [NL-1:0] cmd_lo
);
    logic          en_q;
    logic          force_all;
    logic [NL-1:0] active;

    // Enable return is seen as enabled now but disabled last cycle.
    assign force_all = live && en_side && !en_q;

    // Remember the enable from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_side;
        end
    end

    for (genvar g = 0; g < int'(NL); g++) begin : g_line
        logic send;

        // A line sends on an edge, a scan of a quiet line, or a forced scan.
        assign send = dir_cfg[g] && (edge_v[g] || (tick && !active[g]) || force_all);

        // Activity flag: marks an edge sent in the current scan period.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                active[g] <= 1'b0;
            end else if (tick) begin
                active[g] <= edge_v[g];
            end else if (edge_v[g]) begin
                active[g] <= 1'b1;
            end
        end

        // Registered command pair carrying the new level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmd_hi[g] <= 1'b0;
                cmd_lo[g] <= 1'b0;
            end else begin
                cmd_hi[g] <= send && lvl_next[g];
                cmd_lo[g] <= send && !lvl_next[g];
            end
        end
    end
endmodule

// File: rtl/edge_cmd_tx.sv
// Transition-coded line transmitter with periodic refresh (top level).
// Inputs are synchronized, latched under the side enable and turned into
// one-cycle set-high / set-low commands on each change. A scheduler
// restates quiet lines every REFRESH_CYC cycles.
// Assumes: din bits are level signals; dir_cfg is static while running.
module edge_cmd_tx
    import edge_cmd_tx_pkg::*;
#(
    parameter int unsigned NUM_LINES   = DEF_LINES,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned REFRESH_CYC = 1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_side,
    input  logic [NUM_LINES-1:0] dir_cfg,
    input  logic [NUM_LINES-1:0] din,
    output logic [NUM_LINES-1:0] cmd_hi,
    output logic [NUM_LINES-1:0] cmd_lo
);
    localparam int unsigned WARM_CYC = SYNC_STAGES + 1;

    logic [NUM_LINES-1:0] d_sync;
    logic [NUM_LINES-1:0] lvl_next;
    logic [NUM_LINES-1:0] edge_v;
    logic                 live;
    logic                 tick;

    edge_cmd_tx_sync #(.NL(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (din),
        .d_sync  (d_sync)
    );

    edge_cmd_tx_sched #(.PERIOD(REFRESH_CYC), .WARM(WARM_CYC)) u_sched (
        .clk   (clk),
        .rst_n (rst_n),
        .live  (live),
        .tick  (tick)
    );

    edge_cmd_tx_capture #(.NL(NUM_LINES)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .live     (live),
        .en_side  (en_side),
        .d_sync   (d_sync),
        .lvl_next (lvl_next),
        .edge_v   (edge_v)
    );

    edge_cmd_tx_arb #(.NL(NUM_LINES)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .live     (live),
        .tick     (tick),
        .en_side  (en_side),
        .dir_cfg  (dir_cfg),
        .lvl_next (lvl_next),
        .edge_v   (edge_v),
        .cmd_hi   (cmd_hi),
        .cmd_lo   (cmd_lo)
    );
endmodule

// File: rtl/edge_cmd_tx_chk.sv
// Property checker for edge_cmd_tx, attached with bind.
// Assumes: dir_cfg is static while the block runs.
module edge_cmd_tx_chk #(
    parameter int unsigned NL     = 5,
    parameter int unsigned PERIOD = 1000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_side,
    input logic          live,
    input logic [NL-1:0] dir_cfg,
    input logic [NL-1:0] cmd_hi,
    input logic [NL-1:0] cmd_lo
);
    // R4
    excl_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hi & cmd_lo) == '0);

    // R3
    rx_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_hi | cmd_lo) & ~dir_cfg) == '0);

    // R9
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cmd_hi == '0 && cmd_lo == '0));

    // R8
    en_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && en_side && !$past(en_side)) |=> ((cmd_hi | cmd_lo) == dir_cfg));

    for (genvar g = 0; g < int'(NL); g++) begin : g_gap
        int unsigned gap;

        // Count cycles since the last command on this transmitting line.
        always_ff @(posedge clk) begin
            if (!rst_n || !dir_cfg[g] || cmd_hi[g] || cmd_lo[g]) begin
                gap <= 0;
            end else begin
                gap <= gap + 1;
            end
        end

        // R6
        cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gap <= 2 * PERIOD);
    end
endmodule

bind edge_cmd_tx edge_cmd_tx_chk #(.NL(NUM_LINES), .PERIOD(REFRESH_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_side (en_side),
    .live    (live),
    .dir_cfg (dir_cfg),
    .cmd_hi  (cmd_hi),
    .cmd_lo  (cmd_lo)
);

// File: tb/sim_edge_cmd_tx.sv
`timescale 1ns/1ps
module sim_edge_cmd_tx;
    localparam int unsigned P      = 400;
    localparam int unsigned MINPW  = 5;
    localparam logic [4:0]  TXMASK = 5'b01111;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_side = 1'b1;
    logic [4:0] dir_cfg = TXMASK;
    logic [4:0] din = 5'b00101;
    logic [4:0] cmd_hi;
    logic [4:0] cmd_lo;

    int checks = 0;
    int errors = 0;
    int ph = 0;

    always #2.5 clk = ~clk;

    edge_cmd_tx #(.NUM_LINES(5), .SYNC_STAGES(2), .REFRESH_CYC(P)) u0 (
        .clk(clk), .rst_n(rst_n), .en_side(en_side), .dir_cfg(dir_cfg),
        .din(din), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo)
    );

    // Count clock edges since reset release.
    always @(posedge clk) begin
        if (!rst_n) ph <= 0;
        else        ph <= ph + 1;
    end

    typedef struct packed {
        logic       en;
        logic [4:0] d;
        logic [1:0] dly;
        logic [4:0] hi;
        logic [4:0] lo;
        logic [3:0] tag;
    } row_t;

    localparam row_t ROWS [12] = '{
        '{1'b1, 5'b00111, 2'd3, 5'b00010, 5'b00000, 4'd1},
        '{1'b1, 5'b00011, 2'd3, 5'b00000, 5'b00100, 4'd2},
        '{1'b1, 5'b11100, 2'd3, 5'b01100, 5'b00011, 4'd1},
        '{1'b1, 5'b01100, 2'd3, 5'b00000, 5'b00000, 4'd3},
        '{1'b0, 5'b00011, 2'd3, 5'b00000, 5'b00000, 4'd7},
        '{1'b0, 5'b01010, 2'd3, 5'b00000, 5'b00000, 4'd7},
        '{1'b1, 5'b01010, 2'd1, 5'b01010, 5'b00101, 4'd8},
        '{1'b0, 5'b10101, 2'd3, 5'b00000, 5'b00000, 4'd7},
        '{1'b0, 5'b01010, 2'd3, 5'b00000, 5'b00000, 4'd7},
        '{1'b1, 5'b01010, 2'd1, 5'b01010, 5'b00101, 4'd8},
        '{1'b1, 5'b00000, 2'd3, 5'b00000, 5'b01010, 4'd2},
        '{1'b1, 5'b01111, 2'd3, 5'b01111, 5'b00000, 4'd1}
    };

    function automatic string tag_name(logic [3:0] t);
        case (t)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd7:    return "R7";
            4'd8:    return "R8";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(string tag, logic [4:0] ehi, logic [4:0] elo);
        checks++;
        if (cmd_hi !== ehi || cmd_lo !== elo) begin
            errors++;
            $display("FAIL %s at edge %0d: hi=%b lo=%b expected hi=%b lo=%b",
                     tag, ph, cmd_hi, cmd_lo, ehi, elo);
        end
    endtask

    task automatic to_edge(int n);
        while (ph < n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R9: outputs quiet during reset
        repeat (3) @(negedge clk);
        chk("R9", 5'b0, 5'b0);
        rst_n = 1'b1;
        // R9: silent fill, then a full restatement on edge 4
        to_edge(3); chk("R9", 5'b0, 5'b0);
        to_edge(4); chk("R9", 5'b00101, 5'b01010);
        to_edge(5); chk("R9", 5'b0, 5'b0);

        // Table walk: edges, receivers, freeze, enable return
        for (int i = 0; i < 12; i++) begin
            en_side = ROWS[i].en;
            din     = ROWS[i].d;
            repeat (int'(ROWS[i].dly)) @(posedge clk);
            @(negedge clk);
            chk(tag_name(ROWS[i].tag), ROWS[i].hi, ROWS[i].lo);
            @(negedge clk);
            chk(tag_name(ROWS[i].tag), 5'b0, 5'b0);
        end

        // R5: every line was active in period 0, so the first scan sends nothing
        to_edge(4 + P - 1); chk("R5", 5'b0, 5'b0);
        to_edge(4 + P);     chk("R5", 5'b0, 5'b0);
        // R5/R6: a quiet period gives a full restatement
        to_edge(4 + 2*P - 1); chk("R5", 5'b0, 5'b0);
        to_edge(4 + 2*P);     chk("R6", 5'b01111, 5'b0);

        // R10: low pulse of MINPW cycles on line 0
        to_edge(900); din = 5'b01110;
        to_edge(902); chk("R10", 5'b0, 5'b0);
        to_edge(903); chk("R10", 5'b0, 5'b00001);
        to_edge(900 + MINPW); din = 5'b01111;
        to_edge(907); chk("R10", 5'b0, 5'b0);
        to_edge(908); chk("R10", 5'b00001, 5'b0);

        // R5: line 0 was active, so it is skipped at the next scan
        to_edge(4 + 3*P); chk("R5", 5'b01110, 5'b0);

        // R4: line 2 falls exactly on the scan edge
        to_edge(4 + 4*P - 3); din = 5'b01011;
        to_edge(4 + 4*P - 1); chk("R4", 5'b0, 5'b0);
        to_edge(4 + 4*P);     chk("R4", 5'b01011, 5'b00100);
        to_edge(4 + 4*P + 1); chk("R4", 5'b0, 5'b0);
        // R4/R5: line 2 counted as active, so it is skipped next
        to_edge(4 + 5*P); chk("R5", 5'b01011, 5'b0);

        // R9: reset in mid run with new input levels
        @(negedge clk); rst_n = 1'b0; din = 5'b10011;
        @(negedge clk); @(negedge clk);
        chk("R9", 5'b0, 5'b0);
        rst_n = 1'b1;
        to_edge(3); chk("R9", 5'b0, 5'b0);
        to_edge(4); chk("R9", 5'b00011, 5'b01100);

        finish_run();
    end
endmodule